// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block sits between instruction decode and issue. It takes one decoded three-operand scalar instruction, together with a vector length, a vector/scalar tag per operand and an optional predicate mask. It expands that instruction into a stream of element steps. Each step carries a destination register index, two source register indices, a result-write strobe and a zero-write strobe. A vector-tagged operand walks forward one register per element. A scalar operand stays on its base register. The block raises a one-cycle done pulse when the loop is over, and the program counter may advance only at that point.

Steps leave one per cycle over a valid/ready handshake. When the issue side is not ready, the current step is held unchanged. A masked-out element writes nothing, or writes a zero in zeroing mode, but it still advances every vector-tagged offset. When the destination is scalar, the loop stops after the first active element. This lets a predicate with leading zeros select a source element.

The controller has three states. `ST_IDLE` waits for a start. `ST_RUN` presents element steps. `ST_DONE` holds the one-cycle completion pulse. The transitions are:
- T_LAUNCH: `ST_IDLE` to `ST_RUN`, on a start with a non-zero length.
- T_EMPTY: `ST_IDLE` to `ST_DONE`, on a start with zero length.
- T_STEP: `ST_RUN` to `ST_RUN`, on an accepted step that is not the last.
- T_FINISH: `ST_RUN` to `ST_DONE`, on an accepted step that is the last element or an active element with a scalar destination.
- T_RELEASE: `ST_DONE` to `ST_IDLE`, unconditionally.

Top module: `velem_seq`

## Requirements
- R1: After reset the block is idle: step_valid_o, step_wen_o, step_wzero_o, busy_o and done_o are all 0.
- R2: For element i, a vector-tagged operand's index is its base plus i, and a scalar-tagged operand's index equals its base.
- R3: With a vector destination and length VL ≥ 1, exactly VL steps are issued for elements 0 to VL-1 in order. done_o is 1 in the cycle after the last step is accepted, and busy_o is 1 from the cycle after start until done_o.
- R4: Element i is active when pred_en_i is 1 and bit i of pred_mask_i is 1, or whenever pred_en_i is 0. An active step has step_wen_o = 1.
- R5: An inactive element still advances every vector-tagged index, so the indices of element i are the same whatever the mask bits below i are.
- R6: An inactive step has step_wen_o = 0, and step_wzero_o = 1 if and only if zero_mode_i was 1 at start. step_wen_o and step_wzero_o are never both 1.
- R7: With a scalar destination, the loop ends once the first active element's step is accepted. Vector-tagged sources advance across the leading inactive elements. If no element is active, all VL steps are issued.
- R8: A start with vlen_i = 0 issues no step, and done_o is 1 in the cycle after start.
- R9: While step_valid_o = 1 and step_ready_i = 0, the step is held: in the next cycle valid stays 1 and every index and strobe is unchanged.
- R10: A start while busy_o = 1 is ignored. The running loop keeps the length, tags, bases, mask and mode latched at its own start.
- R11: Index arithmetic wraps modulo 128 (7-bit register indices).
- R12: done_o lasts exactly one cycle. The cycle after it, busy_o is 0 and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| vlen_i | input | 7 | Vector length, 0 to 64 |
| pred_en_i | input | 1 | 1 = use pred_mask_i, 0 = all elements active |
| pred_mask_i | input | 64 | Bit i enables element i |
| zero_mode_i | input | 1 | Inactive elements write zero |
| dst_vec_i | input | 1 | Destination tagged vector |
| srca_vec_i | input | 1 | First source tagged vector |
| srcb_vec_i | input | 1 | Second source tagged vector |
| dst_base_i | input | 7 | Destination base register |
| srca_base_i | input | 7 | First source base register |
| srcb_base_i | input | 7 | Second source base register |
| step_ready_i | input | 1 | Issue side accepts the current step |
| step_valid_o | output | 1 | A step is presented |
| step_dst_o | output | 7 | Destination register index |
| step_srca_o | output | 7 | First source register index |
| step_srcb_o | output | 7 | Second source register index |
| step_wen_o | output | 1 | Write the computed result |
| step_wzero_o | output | 1 | Write zero to the destination |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets five corner cases:
- A scalar destination with leading zero mask bits. A design that froze the sources on masked elements would read the wrong register. A design that did not stop at the first active element would issue extra steps.
- A zero length. A faulty design would emit a spurious step or never finish.
- A full 64-element loop whose bases wrap past register 127. A design with a carry into an eighth bit would produce the wrong indices.
- A start pulse with different operands injected mid-loop. A design that re-latched on it would change the stream.
- Random-looking backpressure. A design that advanced without ready would skip elements.

// File: rtl/velem_pkg.sv
package velem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    localparam int OP_DST = 0;
    localparam int OP_SA  = 1;
    localparam int OP_SB  = 2;
    localparam int NOPS   = 3;

endpackage

// File: rtl/velem_ptr.sv
// Per-operand register index: base, plus the element number when vector-tagged.
module velem_ptr #(
    parameter int IDX_W = 7,
    parameter int EL_W  = 6
) (
    input  logic [IDX_W-1:0] base_i,
    input  logic             is_vec_i,
    input  logic [EL_W-1:0]  elem_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] off;

    always_comb begin
        off   = is_vec_i ? IDX_W'(elem_i) : '0;
        idx_o = base_i + off;   // wraps inside the register index space
    end
endmodule

// File: rtl/velem_pred.sv
// Predicate evaluation for the current element and the write strobes.
module velem_pred #(
    parameter int MAX_VL = 64,
    localparam int EL_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic              pen_i,
    input  logic              zm_i,
    input  logic [EL_W-1:0]   elem_i,
    output logic              active_o,
    output logic              wen_o,
    output logic              wzero_o
);
    always_comb begin
        active_o = !pen_i || mask_i[elem_i];
        wen_o    = valid_i && active_o;
        wzero_o  = valid_i && !active_o && zm_i;
    end

    // R6: result write and zero write never together
    p_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wen_o, wzero_o}));

    // R4: without a predicate every presented step writes
    p_nomask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !pen_i) |-> wen_o);
endmodule

// File: rtl/velem_fsm.sv
// Loop controller: IDLE -> RUN -> DONE -> IDLE, element counter.
module velem_fsm
    import velem_pkg::*;
#(
    parameter int MAX_VL = 64,
    localparam int EL_W  = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VL_W-1:0] vlen_i,
    input  logic            fire_i,
    input  logic            active_i,
    input  logic            dst_vec_i,
    output logic [EL_W-1:0] elem_o,
    output logic            load_o,
    output logic            valid_o,
    output logic            done_o,
    output logic            busy_o
);
    seq_state_e      state_q, state_d;
    logic [EL_W-1:0] elem_q;
    logic [VL_W-1:0] vlen_q;
    logic            last_el;
    logic            finish;

    always_comb begin
        last_el = (VL_W'(elem_q) == vlen_q - VL_W'(1));
        finish  = fire_i && (last_el || (active_i && !dst_vec_i));
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (vlen_i == '0) state_d = ST_DONE;    // T_EMPTY
                    else              state_d = ST_RUN;     // T_LAUNCH
                end
            end
            ST_RUN: begin
                if (finish) state_d = ST_DONE;              // T_FINISH
                else        state_d = ST_RUN;               // T_STEP / hold
            end
            ST_DONE: state_d = ST_IDLE;                     // T_RELEASE
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and element counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            elem_q  <= '0;
            vlen_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                elem_q <= '0;
                vlen_q <= vlen_i;
            end else if (state_q == ST_RUN && fire_i && !finish) begin
                elem_q <= elem_q + EL_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        elem_o  = elem_q;
        load_o  = (state_q == ST_IDLE) && start_i;
        valid_o = (state_q == ST_RUN);
        done_o  = (state_q == ST_DONE);
        busy_o  = (state_q != ST_IDLE);
    end

    // R12: completion pulse is one cycle wide, followed by idle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8: zero-length start goes straight to completion
    p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && vlen_i == '0) |=> (done_o && !valid_o));

    // R3: accepted last element completes the loop
    p_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fire_i && last_el) |=> (done_o && !valid_o));

    // R9: counter does not move without acceptance
    p_hold_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !fire_i) |=> $stable(elem_q));
endmodule

// File: rtl/velem_seq.sv
// Top: latches instruction context at start, issues one element step per cycle.
module velem_seq
    import velem_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int MAX_VL = 64,
    localparam int EL_W  = $clog2(MAX_VL),
    localparam int VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VL_W-1:0]   vlen_i,
    input  logic              pred_en_i,
    input  logic [MAX_VL-1:0] pred_mask_i,
    input  logic              zero_mode_i,
    input  logic              dst_vec_i,
    input  logic              srca_vec_i,
    input  logic              srcb_vec_i,
    input  logic [IDX_W-1:0]  dst_base_i,
    input  logic [IDX_W-1:0]  srca_base_i,
    input  logic [IDX_W-1:0]  srcb_base_i,
    input  logic              step_ready_i,
    output logic              step_valid_o,
    output logic [IDX_W-1:0]  step_dst_o,
    output logic [IDX_W-1:0]  step_srca_o,
    output logic [IDX_W-1:0]  step_srcb_o,
    output logic              step_wen_o,
    output logic              step_wzero_o,
    output logic              busy_o,
    output logic              done_o
);
    logic [IDX_W-1:0]  base_in [NOPS];
    logic              vec_in  [NOPS];
    logic [IDX_W-1:0]  base_q  [NOPS];
    logic              vec_q   [NOPS];
    logic [IDX_W-1:0]  idx     [NOPS];
    logic [MAX_VL-1:0] mask_q;
    logic              pen_q;
    logic              zm_q;
    logic [EL_W-1:0]   elem;
    logic              load;
    logic              valid;
    logic              fire;
    logic              active;

    always_comb begin
        base_in[OP_DST] = dst_base_i;
        base_in[OP_SA]  = srca_base_i;
        base_in[OP_SB]  = srcb_base_i;
        vec_in[OP_DST]  = dst_vec_i;
        vec_in[OP_SA]   = srca_vec_i;
        vec_in[OP_SB]   = srcb_vec_i;
        fire            = valid && step_ready_i;
    end

    // per-operand context register and index generator
    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                vec_q[g]  <= 1'b0;
            end else if (load) begin
                base_q[g] <= base_in[g];
                vec_q[g]  <= vec_in[g];
            end
        end

        velem_ptr #(.IDX_W(IDX_W), .EL_W(EL_W)) u_ptr (
            .base_i   (base_q[g]),
            .is_vec_i (vec_q[g]),
            .elem_i   (elem),
            .idx_o    (idx[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pen_q  <= 1'b0;
            zm_q   <= 1'b0;
        end else if (load) begin
            mask_q <= pred_mask_i;
            pen_q  <= pred_en_i;
            zm_q   <= zero_mode_i;
        end
    end

    velem_fsm #(.MAX_VL(MAX_VL)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .vlen_i    (vlen_i),
        .fire_i    (fire),
        .active_i  (active),
        .dst_vec_i (vec_q[OP_DST]),
        .elem_o    (elem),
        .load_o    (load),
        .valid_o   (valid),
        .done_o    (done_o),
        .busy_o    (busy_o)
    );

    velem_pred #(.MAX_VL(MAX_VL)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid),
        .mask_i   (mask_q),
        .pen_i    (pen_q),
        .zm_i     (zm_q),
        .elem_i   (elem),
        .active_o (active),
        .wen_o    (step_wen_o),
        .wzero_o  (step_wzero_o)
    );

    always_comb begin
        step_valid_o = valid;
        step_dst_o   = idx[OP_DST];
        step_srca_o  = idx[OP_SA];
        step_srcb_o  = idx[OP_SB];
    end

    // R9: a refused step is held unchanged
    p_hold_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && !step_ready_i) |=> (step_valid_o && $stable(step_dst_o)
            && $stable(step_srca_o) && $stable(step_srcb_o)
            && $stable(step_wen_o) && $stable(step_wzero_o)));

    // R2: a scalar destination stays on its base register
    p_scalar_dst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && !vec_q[OP_DST]) |-> (step_dst_o == base_q[OP_DST]));

    // R7: scalar destination ends on the first accepted write
    p_scalar_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_o && step_ready_i && step_wen_o && !vec_q[OP_DST]) |=> done_o);

    // R10: latched context does not change while the loop runs
    p_ctx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (!busy_o || ($stable(base_q[OP_DST]) && $stable(base_q[OP_SA])
            && $stable(base_q[OP_SB]) && $stable(mask_q) && $stable(pen_q))));
endmodule

// File: tb/velem_seq_test.sv
module velem_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    typedef struct packed {
        logic [6:0]  vl;
        logic        dv, av, bv;
        logic [6:0]  db, ab, bb;
        logic        pen;
        logic [63:0] mask;
        logic        zm, bp;
        logic [6:0]  steps;
    } case_t;

    // stimulus and expected step count per case
    localparam case_t CASES [8] = '{
        '{7'd4,  1'b1,1'b1,1'b1, 7'd10, 7'd20, 7'd30, 1'b0, 64'h0,              1'b0,1'b0, 7'd4},
        '{7'd8,  1'b1,1'b1,1'b0, 7'd40, 7'd50, 7'd60, 1'b1, 64'hA5,             1'b0,1'b1, 7'd8},
        '{7'd8,  1'b1,1'b0,1'b1, 7'd40, 7'd50, 7'd60, 1'b1, 64'hA5,             1'b1,1'b0, 7'd8},
        '{7'd6,  1'b0,1'b1,1'b1, 7'd5,  7'd70, 7'd90, 1'b1, 64'h14,             1'b0,1'b1, 7'd3},
        '{7'd5,  1'b0,1'b1,1'b0, 7'd6,  7'd11, 7'd12, 1'b1, 64'h0,              1'b1,1'b0, 7'd5},
        '{7'd64, 1'b1,1'b1,1'b1, 7'd100,7'd120,7'd0,  1'b1, 64'hF0F0_3C3C_0FF0_8001, 1'b1,1'b1, 7'd64},
        '{7'd3,  1'b0,1'b0,1'b0, 7'd1,  7'd2,  7'd3,  1'b0, 64'h0,              1'b0,1'b0, 7'd1},
        '{7'd1,  1'b1,1'b1,1'b1, 7'd127,7'd126,7'd125,1'b1, 64'h0,              1'b1,1'b0, 7'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  vlen_i = '0;
    logic        pred_en_i = 1'b0;
    logic [63:0] pred_mask_i = '0;
    logic        zero_mode_i = 1'b0;
    logic        dst_vec_i = 1'b0, srca_vec_i = 1'b0, srcb_vec_i = 1'b0;
    logic [6:0]  dst_base_i = '0, srca_base_i = '0, srcb_base_i = '0;
    logic        step_ready_i = 1'b0;
    logic        step_valid_o;
    logic [6:0]  step_dst_o, step_srca_o, step_srcb_o;
    logic        step_wen_o, step_wzero_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    velem_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vlen_i(vlen_i),
        .pred_en_i(pred_en_i), .pred_mask_i(pred_mask_i), .zero_mode_i(zero_mode_i),
        .dst_vec_i(dst_vec_i), .srca_vec_i(srca_vec_i), .srcb_vec_i(srcb_vec_i),
        .dst_base_i(dst_base_i), .srca_base_i(srca_base_i), .srcb_base_i(srcb_base_i),
        .step_ready_i(step_ready_i), .step_valid_o(step_valid_o),
        .step_dst_o(step_dst_o), .step_srca_o(step_srca_o), .step_srcb_o(step_srcb_o),
        .step_wen_o(step_wen_o), .step_wzero_o(step_wzero_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic drive_case(input case_t c);
        vlen_i = c.vl; dst_vec_i = c.dv; srca_vec_i = c.av; srcb_vec_i = c.bv;
        dst_base_i = c.db; srca_base_i = c.ab; srcb_base_i = c.bb;
        pred_en_i = c.pen; pred_mask_i = c.mask; zero_mode_i = c.zm;
    endtask

    // Runs one loop; the bench models the expected stream from the requirements.
    task automatic run_case(input case_t c, input bit inject, input string tag);
        int e = 0;
        int n = 0;
        bit exp_done = 0;
        bit held = 0;
        logic [22:0] held_v = '0;
        @(negedge clk);
        drive_case(c);
        start_i = 1'b1;
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (inject && cyc == 2) begin          // R10: foreign start mid-loop
                start_i = 1'b1; vlen_i = 7'd2; dst_base_i = 7'd3;
                srca_base_i = 7'd4; srcb_base_i = 7'd5; pred_mask_i = '1;
            end
            step_ready_i = c.bp ? ((cyc % 3) != 1) : 1'b1;
            if (exp_done) begin
                check(done_o && !step_valid_o, "R3", {tag, " done after last step"},
                      {done_o, step_valid_o}, 2'b10);
                check(n == int'(c.steps), "R7", {tag, " step count"}, n, c.steps);
                @(negedge clk);
                start_i = 1'b0;
                check(!done_o && !busy_o, "R12", {tag, " done one cycle"},
                      {done_o, busy_o}, 2'b00);
                return;
            end
            if (done_o) begin
                check(0, "R3", {tag, " early done"}, n, c.steps);
                return;
            end
            if (cyc == 0)
                check(busy_o && step_valid_o, "R3", {tag, " busy after start"},
                      {busy_o, step_valid_o}, 2'b11);
            if (step_valid_o) begin
                logic act;
                logic [6:0] ed, ea, eb;
                logic [22:0] ev, av;
                act = !c.pen || c.mask[e];
                ed  = c.db + (c.dv ? 7'(e) : 7'd0);   // R2 R5 R11
                ea  = c.ab + (c.av ? 7'(e) : 7'd0);
                eb  = c.bb + (c.bv ? 7'(e) : 7'd0);
                ev  = {ed, ea, eb, act, !act && c.zm}; // R4 R6
                av  = {step_dst_o, step_srca_o, step_srcb_o, step_wen_o, step_wzero_o};
                check(av == ev, "R2", {tag, " step fields"}, av, ev);
                if (held)
                    check(av == held_v, "R9", {tag, " held step"}, av, held_v);
                held = 0;
                if (step_ready_i) begin
                    n++;
                    if ((act && !c.dv) || e == int'(c.vl) - 1) exp_done = 1;
                    else e++;
                end else begin
                    held = 1;
                    held_v = av;
                end
            end else begin
                check(0, "R3", {tag, " valid dropped"}, 0, 1);
                return;
            end
        end
        check(0, "R3", {tag, " loop never ended"}, n, c.steps);
    endtask

    initial begin
        case_t z;
        repeat (3) @(negedge clk);
        // R1: reset state
        check({step_valid_o, step_wen_o, step_wzero_o, busy_o, done_o} == 5'b0,
              "R1", "reset outputs",
              {step_valid_o, step_wen_o, step_wzero_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !step_valid_o, "R1", "idle after release",
              {busy_o, step_valid_o}, 0);

        for (int k = 0; k < 8; k++)
            run_case(CASES[k], 1'b0, $sformatf("case%0d", k));

        // R10: start injected while busy is ignored
        run_case(CASES[1], 1'b1, "inject");

        // R8: zero-length loop
        z = CASES[0];
        z.vl = 7'd0;
        @(negedge clk);
        drive_case(z);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && !step_valid_o, "R8", "zero length done",
              {done_o, step_valid_o}, 2'b10);
        @(negedge clk);
        check(!done_o && !busy_o, "R12", "zero length release",
              {done_o, busy_o}, 2'b00);

        // R12: back-to-back start accepted right after release
        run_case(CASES[6], 1'b0, "restart");

        finish_run();
    end
endmodule